// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable stand-in for a 16 Kbit serial EEPROM that is reached over a three-wire select/clock/data link. The serial inputs pass through synchronisers and are sampled on a free-running system clock. A host frames each command between a rising and a falling select: first a start bit, then a two-bit opcode, then an address, and for commands that carry data, a data field. The block keeps its contents in an internal word array.

A strap input sets the organisation at run time. With the strap high the array holds 1024 words of 16 bits. With it low the array holds 2048 bytes of 8 bits. A second strap, the program enable, blocks every command that would change the array. Commands that change the array are also refused until an enable command has been issued. Each accepted change starts a self-timed program cycle that is counted in system clocks. During that cycle the serial output reports busy or ready whenever select is high. The serial output is given as a data bit plus an output enable, which a pad cell combines into a tri-state pin.

Top module: `mwe_slave`

## Requirements
- R1: A frame starts at the first rising serial clock with select high and data-in high. Clocks with select low, and zero bits sent before the start bit, have no effect.
- R2: After the start bit the opcode decodes as 10 read, 01 write and 11 erase. Opcode 00 takes its command from the two most significant address bits: 11 enable, 10 erase-all, 01 write-all, 00 disable.
- R3: With the organisation strap high, addresses are 10 bits wide and data is 16 bits. With it low, addresses are 11 bits wide and data is 8 bits, and byte address bit 0 set to 1 selects the upper half of the 16-bit word at byte address bits 10:1.
- R4: A read drives one 0 bit on the output after the last address bit. It then sends the data MSB first, one bit per serial clock. The address then advances and wraps from the top of the array to 0 for as long as select stays high.
- R5: The output enable is low except while read data or a program status is being shown, and it drops within a few system clocks after select falls.
- R6: After an accepted change command ends with select falling, raising select shows 0 while the program cycle runs and 1 once it has ended.
- R7: After reset, change commands are refused. The enable command allows them and the disable command refuses them again.
- R8: While the program-enable strap is low, change commands leave the array untouched and start no program cycle.
- R9: Erase sets a location to all ones and erase-all sets every word to all ones. Write-all stores its pattern in every location, replacing any earlier contents. In byte mode the pattern fills both halves of each word.
- R10: A command whose opcode, address or data bits were not all clocked in before select falls has no effect.
- R11: Frames sent while a program cycle runs are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Serial select, active high |
| sck_i | input | 1 | Serial clock, data-in sampled on its rise |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organisation strap: 1 = 16-bit words, 0 = bytes |
| pe_i | input | 1 | Program enable strap, low blocks changes |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for the serial data pin |

## Verification
The bench sends zero bits before a start bit. A design that starts a frame on select alone would shift the frame and read the wrong word. Sequential reads run across the top address in both organisations. A design that fails to wrap the address, or that handles word and byte addresses the same way, returns wrong data. Byte writes and byte erases are read back as whole words, which shows a lane error as a corrupted neighbour byte. Change commands are then sent with the program enable low, after a disable command, cut short, and while a write-all is still running. A design that honours any of these shows a program status on the output or returns data that differs from the scoreboard.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_READ,
        ST_HOLD
    } mwe_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_ERASE,
        CMD_EWEN,
        CMD_EWDS,
        CMD_ERAL,
        CMD_WRAL
    } mwe_cmd_e;

endpackage

// File: rtl/mwe_sync.sv
module mwe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mwe_prog_timer.sv
module mwe_prog_timer #(
    parameter int TW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [TW-1:0] len_i,
    output logic          busy_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)             cnt_d = len_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R11: a new program cycle is only launched from the idle timer
    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/mwe_word_array.sv
module mwe_word_array #(
    parameter int DEPTH = 1024,
    parameter int LANES = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [AW-1:0]      waddr_i,
    input  logic [8*LANES-1:0] wdata_i,
    input  logic [LANES-1:0]   wbe_i,
    input  logic [AW-1:0]      raddr_i,
    output logic [8*LANES-1:0] rdata_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && wbe_i[g]) mem_q[waddr_i] <= wdata_i[8*g +: 8];
        end

        assign rdata_o[8*g +: 8] = mem_q[raddr_i];
    end
endmodule

// File: rtl/mwe_slave.sv
module mwe_slave
    import mwe_pkg::*;
#(
    parameter int WORDS   = 1024,
    parameter int T_WRITE = 40,
    parameter int T_ERAL  = 1100,
    parameter int T_WRAL  = 1200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic di_i,
    input  logic org_i,
    input  logic pe_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int AW   = $clog2(WORDS);
    localparam int BAW  = AW + 1;
    localparam int CW   = $clog2(2 + BAW + 16 + 1);
    localparam int TMAX = (T_WRAL > T_ERAL) ? ((T_WRAL > T_WRITE) ? T_WRAL : T_WRITE)
                                            : ((T_ERAL > T_WRITE) ? T_ERAL : T_WRITE);
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] HDR16  = CW'(2 + AW);
    localparam logic [CW-1:0] HDR8   = CW'(2 + BAW);
    localparam logic [CW-1:0] FULL16 = CW'(2 + AW + 16);
    localparam logic [CW-1:0] FULL8  = CW'(2 + BAW + 8);

    typedef struct packed {
        mwe_state_e     st;
        mwe_cmd_e       cmd;
        logic           cs_p;
        logic           sck_p;
        logic           x8;
        logic [CW-1:0]  cnt;
        logic [14:0]    sh;
        logic [BAW-1:0] addr;
        logic [15:0]    data;
        logic           pend;
        logic           wen;
        logic           stat;
        logic [15:0]    osh;
        logic [3:0]     ocnt;
        logic           dout;
        logic           oe;
        logic           sweep;
        logic [AW-1:0]  ptr;
        logic [15:0]    fill;
    } mwe_regs_t;

    mwe_regs_t r_q, r_d;

    logic cs_s, sck_s, di_s;
    logic busy, cs_fall, sck_rise, prog_start;
    logic [TW-1:0] prog_len;
    logic we;
    logic [AW-1:0] waddr, raddr;
    logic [15:0] wdata, rdata, word, sh_full;
    logic [1:0] wbe, op, sel;
    logic [BAW-1:0] hdr_addr, next_addr;
    logic [CW-1:0] cnt_nx, hdr_len, full_len;

    mwe_sync #(.W(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_i, sck_i, di_i}),
        .q_o   ({cs_s, sck_s, di_s})
    );

    mwe_prog_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .len_i   (prog_len),
        .busy_o  (busy)
    );

    mwe_word_array #(.DEPTH(WORDS), .LANES(2)) u_array (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .wbe_i   (wbe),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    assign cs_fall  = r_q.cs_p & ~cs_s;
    assign sck_rise = sck_s & ~r_q.sck_p;
    assign raddr    = r_q.x8 ? r_q.addr[BAW-1:1] : r_q.addr[AW-1:0];

    always_comb begin
        r_d        = r_q;
        r_d.cs_p   = cs_s;
        r_d.sck_p  = sck_s;
        sh_full    = {r_q.sh, di_s};
        cnt_nx     = r_q.cnt + CW'(1);
        hdr_len    = r_q.x8 ? HDR8 : HDR16;
        full_len   = r_q.x8 ? FULL8 : FULL16;
        op         = r_q.x8 ? sh_full[BAW+1:BAW] : sh_full[AW+1:AW];
        sel        = r_q.x8 ? sh_full[BAW-1:BAW-2] : sh_full[AW-1:AW-2];
        hdr_addr   = r_q.x8 ? sh_full[BAW-1:0] : {1'b0, sh_full[AW-1:0]};
        next_addr  = r_q.x8 ? r_q.addr + BAW'(1) : {1'b0, r_q.addr[AW-1:0] + AW'(1)};
        word       = !r_q.x8 ? rdata :
                     (r_q.addr[0] ? {rdata[15:8], 8'h00} : {rdata[7:0], 8'h00});
        prog_start = 1'b0;
        prog_len   = '0;
        we         = 1'b0;
        waddr      = raddr;
        wdata      = '1;
        wbe        = 2'b11;

        // whole-array sweep for erase-all and write-all, one word per clock
        if (r_q.sweep) begin
            we        = 1'b1;
            waddr     = r_q.ptr;
            wdata     = r_q.fill;
            r_d.ptr   = r_q.ptr + AW'(1);
            if (r_q.ptr == AW'(WORDS - 1)) r_d.sweep = 1'b0;
        end

        if (cs_fall) begin
            if (r_q.pend && !busy) begin
                case (r_q.cmd)
                    CMD_EWEN: r_d.wen = 1'b1;
                    CMD_EWDS: r_d.wen = 1'b0;
                    default: begin
                        if (r_q.wen && pe_i) begin
                            prog_start = 1'b1;
                            r_d.stat   = 1'b1;
                            case (r_q.cmd)
                                CMD_WRITE, CMD_ERASE: begin
                                    prog_len = TW'(T_WRITE);
                                    we       = 1'b1;
                                    if (r_q.cmd == CMD_WRITE)
                                        wdata = r_q.x8 ? {2{r_q.data[7:0]}} : r_q.data;
                                    if (r_q.x8) wbe = r_q.addr[0] ? 2'b10 : 2'b01;
                                end
                                CMD_ERAL: begin
                                    prog_len  = TW'(T_ERAL);
                                    r_d.sweep = 1'b1;
                                    r_d.ptr   = '0;
                                    r_d.fill  = '1;
                                end
                                default: begin
                                    prog_len  = TW'(T_WRAL);
                                    r_d.sweep = 1'b1;
                                    r_d.ptr   = '0;
                                    r_d.fill  = r_q.x8 ? {2{r_q.data[7:0]}} : r_q.data;
                                end
                            endcase
                        end
                    end
                endcase
            end
            r_d.st   = ST_IDLE;
            r_d.pend = 1'b0;
            r_d.oe   = 1'b0;
        end else if (!cs_s) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    r_d.oe   = r_q.stat;
                    r_d.dout = ~busy;
                    if (sck_rise && di_s && !busy) begin
                        r_d.st   = ST_SHIFT;
                        r_d.cnt  = '0;
                        r_d.stat = 1'b0;
                        r_d.oe   = 1'b0;
                        r_d.x8   = ~org_i;
                        r_d.cmd  = CMD_NONE;
                    end
                end
                ST_SHIFT: begin
                    if (sck_rise) begin
                        r_d.sh  = sh_full[14:0];
                        r_d.cnt = cnt_nx;
                        if (cnt_nx == hdr_len) begin
                            r_d.addr = hdr_addr;
                            case (op)
                                2'b10: begin
                                    r_d.st   = ST_READ;
                                    r_d.oe   = 1'b1;
                                    r_d.dout = 1'b0;
                                    r_d.ocnt = '0;
                                end
                                2'b01: r_d.cmd = CMD_WRITE;
                                2'b11: begin
                                    r_d.cmd  = CMD_ERASE;
                                    r_d.pend = 1'b1;
                                    r_d.st   = ST_HOLD;
                                end
                                default: begin
                                    case (sel)
                                        2'b11:   r_d.cmd = CMD_EWEN;
                                        2'b10:   r_d.cmd = CMD_ERAL;
                                        2'b01:   r_d.cmd = CMD_WRAL;
                                        default: r_d.cmd = CMD_EWDS;
                                    endcase
                                    if (sel != 2'b01) begin
                                        r_d.pend = 1'b1;
                                        r_d.st   = ST_HOLD;
                                    end
                                end
                            endcase
                        end else if (cnt_nx == full_len) begin
                            r_d.data = r_q.x8 ? {8'h00, sh_full[7:0]} : sh_full;
                            r_d.pend = 1'b1;
                            r_d.st   = ST_HOLD;
                        end
                    end
                end
                ST_READ: begin
                    if (sck_rise) begin
                        if (r_q.ocnt == '0) begin
                            r_d.dout = word[15];
                            r_d.osh  = {word[14:0], 1'b0};
                            r_d.ocnt = r_q.x8 ? 4'd7 : 4'd15;
                        end else begin
                            r_d.dout = r_q.osh[15];
                            r_d.osh  = {r_q.osh[14:0], 1'b0};
                            r_d.ocnt = r_q.ocnt - 4'd1;
                            if (r_q.ocnt == 4'd1) r_d.addr = next_addr;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign do_o    = r_q.dout;
    assign do_oe_o = r_q.oe;

    // R9: the array changes only inside a program cycle or at its launch
    p_write_in_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (busy || prog_start));

    // R9: the whole-array sweep never outlives the timed cycle
    p_sweep_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sweep |-> busy);

    // R2: the bit counter never passes the longest frame
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= FULL16 || r_q.cnt <= FULL8);

    // R7: writes become enabled only when a frame closes
    p_wen_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.wen) |-> $past(cs_fall));

    // R5: the output is released right after select falls
    p_oe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_fall) |-> !do_oe_o);

    // R6: status reads low while the timer keeps running
    p_status_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && do_oe_o && busy && $past(busy)) |-> !do_o);
endmodule

// File: tb/mwe_slave_bench.sv
module mwe_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1, pe = 1'b1;
    logic do_w, oe_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwe_slave u_mwe_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs),
        .sck_i   (sck),
        .di_i    (di),
        .org_i   (org),
        .pe_i    (pe),
        .do_o    (do_w),
        .do_oe_o (oe_w)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] obs_q [$];
    logic [15:0] mon_o, mon_e;
    string       mon_t;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input logic b, output logic s);
        di = b;
        idle(HALF);
        s = do_w;
        sck = 1'b1;
        idle(HALF);
        sck = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic s;
        for (int i = n - 1; i >= 0; i--) tick(v[i], s);
    endtask

    task automatic begin_frame;
        cs = 1'b1;
        idle(HALF);
    endtask

    task automatic end_frame;
        idle(2);
        cs = 1'b0;
        di = 1'b0;
        idle(8);
    endtask

    task automatic command(input logic [1:0] op, input logic [31:0] a,
                           input logic [31:0] d, input int ndb);
        int nab;
        nab = org ? 10 : 11;
        begin_frame;
        send(32'd1, 1);
        send(32'(op), 2);
        send(a, nab);
        send(d, ndb);
        end_frame;
    endtask

    task automatic expect_word(input logic [15:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // driver: reads nw words, pushes what it sees for the monitor
    task automatic read_words(input logic [31:0] a, input int nw, input int lead);
        int nab, w;
        logic s;
        logic [15:0] acc;
        nab = org ? 10 : 11;
        w   = org ? 16 : 8;
        begin_frame;
        send(32'd0, lead);
        send(32'd1, 1);
        send(32'b10, 2);
        send(a, nab);
        tick(1'b0, s);
        chk(oe_w === 1'b1 && s === 1'b0, "R4", "dummy zero before data", {oe_w, s}, 2'b10);
        for (int k = 0; k < nw; k++) begin
            acc = '0;
            for (int b = 0; b < w; b++) begin
                tick(1'b0, s);
                acc = {acc[14:0], s};
            end
            obs_q.push_back(acc);
        end
        end_frame;
        chk(oe_w === 1'b0, "R5", "output released after read", oe_w, 0);
    endtask

    task automatic poll(input bit expect_cycle, input string req);
        int t;
        idle(4);
        cs = 1'b1;
        idle(8);
        if (expect_cycle) begin
            chk(oe_w === 1'b1 && do_w === 1'b0, "R6", "busy status low", {oe_w, do_w}, 2'b10);
            t = 0;
            while (do_w !== 1'b1 && t < 6000) begin
                idle(1);
                t++;
            end
            chk(oe_w === 1'b1 && do_w === 1'b1, "R6", "ready status high", {oe_w, do_w}, 2'b11);
        end else begin
            chk(oe_w === 1'b0, req, "no program cycle started", oe_w, 0);
        end
        cs = 1'b0;
        idle(6);
        chk(oe_w === 1'b0, "R5", "released after select low", oe_w, 0);
    endtask

    // monitor: compares each observed word with the scoreboard head
    initial begin
        forever begin
            wait (obs_q.size() > 0);
            mon_o = obs_q.pop_front();
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk(mon_o === mon_e, mon_t, "read word", 32'(mon_o), 32'(mon_e));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic s;
        idle(3);
        rst_n = 1'b1;
        idle(5);
        chk(oe_w === 1'b0, "R5", "output disabled after reset", oe_w, 0);

        // R1: clocks with select low and zeros with select high do nothing
        di = 1'b1;
        for (int i = 0; i < 4; i++) begin
            idle(HALF); sck = 1'b1; idle(HALF); sck = 1'b0;
        end
        chk(oe_w === 1'b0, "R1", "no activity with select low", oe_w, 0);
        begin_frame;
        send(32'd0, 5);
        chk(oe_w === 1'b0, "R1", "zeros before start ignored", oe_w, 0);
        end_frame;

        // R7, R9: enable, erase all, read with leading zeros
        command(2'b00, 32'h300, 0, 0);
        command(2'b00, 32'h200, 0, 0);
        poll(1'b1, "R9");
        expect_word(16'hFFFF, "R1 R9 erased word");
        read_words(32'd5, 1, 2);

        // R2, R4: writes and sequential read across the top
        command(2'b01, 32'd5, 32'hA5C3, 16);
        poll(1'b1, "R2");
        command(2'b01, 32'd1023, 32'h1234, 16);
        poll(1'b1, "R2");
        command(2'b01, 32'd0, 32'hBEEF, 16);
        poll(1'b1, "R2");
        expect_word(16'h1234, "R4 word at top");
        expect_word(16'hBEEF, "R4 wrap to 0");
        read_words(32'd1023, 2, 0);
        expect_word(16'hA5C3, "R2 written word");
        read_words(32'd5, 1, 0);

        // R3: byte organisation
        org = 1'b0;
        expect_word(16'h00C3, "R3 low byte");
        expect_word(16'h00A5, "R3 high byte");
        read_words(32'd10, 2, 0);
        expect_word(16'h0012, "R4 byte at top");
        expect_word(16'h00EF, "R4 byte wrap");
        read_words(32'd2047, 2, 0);
        command(2'b01, 32'd11, 32'h7E, 8);
        poll(1'b1, "R3");
        command(2'b11, 32'd10, 0, 0);
        poll(1'b1, "R9");
        org = 1'b1;
        expect_word(16'h7EFF, "R3 R9 byte write and erase");
        read_words(32'd5, 1, 0);

        // R8: program enable low
        pe = 1'b0;
        command(2'b01, 32'd5, 32'h0000, 16);
        poll(1'b0, "R8");
        pe = 1'b1;
        expect_word(16'h7EFF, "R8 blocked write");
        read_words(32'd5, 1, 0);

        // R7: disabled writes
        command(2'b00, 32'h000, 0, 0);
        command(2'b01, 32'd5, 32'h0000, 16);
        poll(1'b0, "R7");
        command(2'b00, 32'h200, 0, 0);
        poll(1'b0, "R7");
        expect_word(16'h7EFF, "R7 write refused");
        expect_word(16'hBEEF, "R7 erase-all refused");
        read_words(32'd5, 1, 0);
        read_words(32'd0, 1, 0);

        // R10: cut-short write
        command(2'b00, 32'h300, 0, 0);
        begin_frame;
        send(32'd1, 1);
        send(32'b01, 2);
        send(32'd5, 10);
        send(32'd0, 8);
        end_frame;
        poll(1'b0, "R10");
        expect_word(16'h7EFF, "R10 partial frame");
        read_words(32'd5, 1, 0);

        // R9, R11: write-all and a frame sent while busy
        command(2'b00, 32'h100, 32'h5A5A, 16);
        command(2'b01, 32'd3, 32'h0000, 16);
        poll(1'b1, "R11");
        expect_word(16'h5A5A, "R11 busy frame ignored");
        expect_word(16'h5A5A, "R9 write-all");
        read_words(32'd3, 1, 0);
        read_words(32'd1023, 1, 0);

        // R9, R3: byte write-all fills both halves
        org = 1'b0;
        command(2'b00, 32'h200, 32'h3C, 8);
        poll(1'b1, "R9");
        org = 1'b1;
        expect_word(16'h3C3C, "R3 R9 byte write-all");
        read_words(32'd9, 1, 0);

        tick(1'b0, s);
        wait (obs_q.size() == 0);
        idle(2);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule